// File: doc/BRIEF.md
# Display list commit queue controller

This block keeps track of which register-list handles one output channel is using. There are three slots. The active slot holds the list the hardware is executing now. The queued slot holds the list whose header address has already been handed to the hardware. The pending slot holds the newest list that arrived too late to be handed over safely. Software-side logic raises a commit with a list handle and two flags: internal-notify and writeback. The block decides whether that handle goes to the header-address register at once or waits in the pending slot. At every frame end it moves the slots along and reports what has finished.

Two modes exist. In continuous mode the hardware loops on the list it has, and a commit that races with the hardware replaces the pending list, so only the latest one is kept. Completion is held back by a frame whenever the hardware has not yet taken the queued update. In single-shot mode each commit starts the hardware directly, and every frame end retires the active list. Each handle that leaves a slot is announced on a per-slot release strobe, so the owner can recycle its memory.

Top module: `dlq_commit_queue`

## Requirements
- R1: After reset all outputs are 0 and all three slots are empty. A frame end in continuous mode with empty slots then reports nothing. `hdr_handle_o` and every `rel_handle_o` slice read 0 whenever their strobe is low.
- R2: In continuous mode (`mode_single_i`=0), a commit while the update is busy (queued slot occupied and `hw_upd_i`=1) gives no header write. A handle already pending is released on `rel_o[2]` with its handle in `rel_handle_o` bits [3*HW-1:2*HW]. The new handle becomes pending.
- R3: In continuous mode, a commit while the update is not busy writes the handle to the header (`hdr_wr_o`=1, `hdr_handle_o`). A handle already queued is released on `rel_o[1]` (bits [2*HW-1:HW]). The new handle becomes queued.
- R4: `hw_upd_i` is ignored while the queued slot is empty.
- R5: In continuous mode, a frame end while the update is busy, or while `field_bottom_i`=1, changes no slot and raises no output.
- R6: Otherwise, a continuous frame end with a queued handle makes that handle active. The previous active handle is released on `rel_o[0]` (bits [HW-1:0]). `done_o` is raised, and `notify_o` is raised if the promoted handle was committed with notify.
- R7: In that same frame end, a pending handle is written to the header and becomes queued, and the pending slot empties.
- R8: A continuous frame end that is not held off raises `wb_o` if the active handle carries writeback, then clears that flag, so the next frame end reports no writeback for it.
- R9: In single-shot mode a commit writes the header and makes the handle active. A handle already active is released on `rel_o[0]`.
- R10: In single-shot mode every frame end raises `done_o` and releases the active handle if there is one.
- R11: `err_o` is raised, together with `rel_o[2]`, when a continuous commit replaces a pending handle that carries notify.
- R12: `drain_i` releases every occupied slot in one cycle and empties all three. It overrides commit and frame end, and raises no other output.
- R13: In continuous mode a frame end coinciding with a commit is not acted on. In single-shot mode the frame end retires the old active handle first, then the commit installs the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drain_i | input | 1 | Release and empty all slots |
| mode_single_i | input | 1 | 1 = single-shot, 0 = continuous |
| commit_i | input | 1 | Commit request |
| commit_handle_i | input | HW | Handle of the committed list |
| commit_notify_i | input | 1 | Internal-notify flag of the commit |
| commit_wb_i | input | 1 | Writeback flag of the commit |
| frame_end_i | input | 1 | Frame end event |
| hw_upd_i | input | 1 | Hardware still holds an untaken header update |
| field_bottom_i | input | 1 | Current field is the bottom field |
| hdr_wr_o | output | 1 | Header-address write strobe |
| hdr_handle_o | output | HW | Handle to write to the header register |
| rel_o | output | 3 | Release strobes: bit0 active, bit1 queued, bit2 pending |
| rel_handle_o | output | 3*HW | Released handles, slice per slot as in rel_o |
| done_o | output | 1 | Completion |
| notify_o | output | 1 | Internal-notify completion |
| wb_o | output | 1 | Writeback completion |
| err_o | output | 1 | Notify-carrying pending handle was overwritten |

## Verification
Every result is registered. The outputs for a commit, frame end or drain show up in the cycle right after the cycle those inputs were presented, and `hw_upd_i` and `field_bottom_i` are judged in that same input cycle. The bench changes inputs on the falling edge. It updates its behavioural slot model with those inputs, then compares the complete output vector 2 ns after the next rising edge, so each comparison sees exactly the reaction to one input cycle. Directed steps cover each race and ordering case, and a long pseudo-random continuous run mixes commits, frame ends, busy and bottom-field states.

// File: rtl/dlq_pkg.sv
package dlq_pkg;
  localparam int unsigned NSLOT    = 3;
  localparam int unsigned SLOT_ACT = 0;
  localparam int unsigned SLOT_QUE = 1;
  localparam int unsigned SLOT_PEN = 2;

  typedef struct packed {
    logic notify;
    logic wb;
  } lflags_t;
endpackage

// File: rtl/dlq_slot.sv
module dlq_slot import dlq_pkg::*; #(
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          nxt_valid_i,
  input  logic [HW-1:0] nxt_handle_i,
  input  lflags_t       nxt_flags_i,
  output logic          valid_o,
  output logic [HW-1:0] handle_o,
  output lflags_t       flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      handle_o <= '0;
      flags_o  <= '0;
    end else if (en_i) begin
      valid_o  <= nxt_valid_i;
      handle_o <= nxt_handle_i;
      flags_o  <= nxt_flags_i;
    end
  end
endmodule

// File: rtl/dlq_ctrl.sv
module dlq_ctrl import dlq_pkg::*; #(
  parameter int unsigned HW = 8
) (
  input  logic                      drain_i,
  input  logic                      single_i,
  input  logic                      commit_i,
  input  logic [HW-1:0]             commit_handle_i,
  input  lflags_t                   commit_flags_i,
  input  logic                      frame_end_i,
  input  logic                      hw_upd_i,
  input  logic                      bottom_i,
  input  logic [NSLOT-1:0]          cur_v_i,
  input  logic [NSLOT-1:0][HW-1:0]  cur_h_i,
  input  lflags_t [NSLOT-1:0]       cur_f_i,
  output logic [NSLOT-1:0]          we_o,
  output logic [NSLOT-1:0]          nxt_v_o,
  output logic [NSLOT-1:0][HW-1:0]  nxt_h_o,
  output lflags_t [NSLOT-1:0]       nxt_f_o,
  output logic                      hdr_wr_o,
  output logic [HW-1:0]             hdr_handle_o,
  output logic [NSLOT-1:0]          rel_o,
  output logic [NSLOT-1:0][HW-1:0]  rel_h_o,
  output logic                      done_o,
  output logic                      notify_o,
  output logic                      wb_o,
  output logic                      err_o
);
  logic busy;
  assign busy = cur_v_i[SLOT_QUE] & hw_upd_i;

  always_comb begin
    we_o         = '0;
    nxt_v_o      = cur_v_i;
    nxt_h_o      = cur_h_i;
    nxt_f_o      = cur_f_i;
    hdr_wr_o     = 1'b0;
    hdr_handle_o = '0;
    rel_o        = '0;
    rel_h_o      = '0;
    done_o       = 1'b0;
    notify_o     = 1'b0;
    wb_o         = 1'b0;
    err_o        = 1'b0;

    if (drain_i) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (cur_v_i[s]) begin
          rel_o[s]   = 1'b1;
          rel_h_o[s] = cur_h_i[s];
        end
        nxt_v_o[s] = 1'b0;
        we_o[s]    = 1'b1;
      end
    end else if (single_i) begin
      if (frame_end_i) begin
        done_o = 1'b1;
        if (cur_v_i[SLOT_ACT]) begin
          rel_o[SLOT_ACT]   = 1'b1;
          rel_h_o[SLOT_ACT] = cur_h_i[SLOT_ACT];
        end
        nxt_v_o[SLOT_ACT] = 1'b0;
        we_o[SLOT_ACT]    = 1'b1;
      end
      if (commit_i) begin
        hdr_wr_o     = 1'b1;
        hdr_handle_o = commit_handle_i;
        if (cur_v_i[SLOT_ACT] && !frame_end_i) begin
          rel_o[SLOT_ACT]   = 1'b1;
          rel_h_o[SLOT_ACT] = cur_h_i[SLOT_ACT];
        end
        nxt_v_o[SLOT_ACT] = 1'b1;
        nxt_h_o[SLOT_ACT] = commit_handle_i;
        nxt_f_o[SLOT_ACT] = commit_flags_i;
        we_o[SLOT_ACT]    = 1'b1;
      end
    end else if (commit_i) begin
      if (busy) begin
        if (cur_v_i[SLOT_PEN]) begin
          rel_o[SLOT_PEN]   = 1'b1;
          rel_h_o[SLOT_PEN] = cur_h_i[SLOT_PEN];
          err_o             = cur_f_i[SLOT_PEN].notify;
        end
        nxt_v_o[SLOT_PEN] = 1'b1;
        nxt_h_o[SLOT_PEN] = commit_handle_i;
        nxt_f_o[SLOT_PEN] = commit_flags_i;
        we_o[SLOT_PEN]    = 1'b1;
      end else begin
        hdr_wr_o     = 1'b1;
        hdr_handle_o = commit_handle_i;
        if (cur_v_i[SLOT_QUE]) begin
          rel_o[SLOT_QUE]   = 1'b1;
          rel_h_o[SLOT_QUE] = cur_h_i[SLOT_QUE];
        end
        nxt_v_o[SLOT_QUE] = 1'b1;
        nxt_h_o[SLOT_QUE] = commit_handle_i;
        nxt_f_o[SLOT_QUE] = commit_flags_i;
        we_o[SLOT_QUE]    = 1'b1;
      end
    end else if (frame_end_i && !busy && !bottom_i) begin
      if (cur_v_i[SLOT_ACT] && cur_f_i[SLOT_ACT].wb) begin
        wb_o                 = 1'b1;
        nxt_f_o[SLOT_ACT].wb = 1'b0;
        we_o[SLOT_ACT]       = 1'b1;
      end
      if (cur_v_i[SLOT_QUE]) begin
        done_o   = 1'b1;
        notify_o = cur_f_i[SLOT_QUE].notify;
        if (cur_v_i[SLOT_ACT]) begin
          rel_o[SLOT_ACT]   = 1'b1;
          rel_h_o[SLOT_ACT] = cur_h_i[SLOT_ACT];
        end
        nxt_v_o[SLOT_ACT] = 1'b1;
        nxt_h_o[SLOT_ACT] = cur_h_i[SLOT_QUE];
        nxt_f_o[SLOT_ACT] = cur_f_i[SLOT_QUE];
        we_o[SLOT_ACT]    = 1'b1;
        we_o[SLOT_QUE]    = 1'b1;
        if (cur_v_i[SLOT_PEN]) begin
          hdr_wr_o          = 1'b1;
          hdr_handle_o      = cur_h_i[SLOT_PEN];
          nxt_v_o[SLOT_QUE] = 1'b1;
          nxt_h_o[SLOT_QUE] = cur_h_i[SLOT_PEN];
          nxt_f_o[SLOT_QUE] = cur_f_i[SLOT_PEN];
          nxt_v_o[SLOT_PEN] = 1'b0;
          we_o[SLOT_PEN]    = 1'b1;
        end else begin
          nxt_v_o[SLOT_QUE] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dlq_outreg.sv
module dlq_outreg import dlq_pkg::*; #(
  parameter int unsigned HW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_wr_i,
  input  logic [HW-1:0]        hdr_handle_i,
  input  logic [NSLOT-1:0]     rel_i,
  input  logic [NSLOT*HW-1:0]  rel_h_i,
  input  logic                 done_i,
  input  logic                 notify_i,
  input  logic                 wb_i,
  input  logic                 err_i,
  output logic                 hdr_wr_o,
  output logic [HW-1:0]        hdr_handle_o,
  output logic [NSLOT-1:0]     rel_o,
  output logic [NSLOT*HW-1:0]  rel_h_o,
  output logic                 done_o,
  output logic                 notify_o,
  output logic                 wb_o,
  output logic                 err_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_wr_o     <= 1'b0;
      hdr_handle_o <= '0;
      rel_o        <= '0;
      rel_h_o      <= '0;
      done_o       <= 1'b0;
      notify_o     <= 1'b0;
      wb_o         <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      hdr_wr_o     <= hdr_wr_i;
      hdr_handle_o <= hdr_handle_i;
      rel_o        <= rel_i;
      rel_h_o      <= rel_h_i;
      done_o       <= done_i;
      notify_o     <= notify_i;
      wb_o         <= wb_i;
      err_o        <= err_i;
    end
  end
endmodule

// File: rtl/dlq_commit_queue.sv
module dlq_commit_queue import dlq_pkg::*; #(
  parameter int unsigned HW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                drain_i,
  input  logic                mode_single_i,
  input  logic                commit_i,
  input  logic [HW-1:0]       commit_handle_i,
  input  logic                commit_notify_i,
  input  logic                commit_wb_i,
  input  logic                frame_end_i,
  input  logic                hw_upd_i,
  input  logic                field_bottom_i,
  output logic                hdr_wr_o,
  output logic [HW-1:0]       hdr_handle_o,
  output logic [NSLOT-1:0]    rel_o,
  output logic [NSLOT*HW-1:0] rel_handle_o,
  output logic                done_o,
  output logic                notify_o,
  output logic                wb_o,
  output logic                err_o
);
  logic [NSLOT-1:0]         slot_v;
  logic [NSLOT-1:0][HW-1:0] slot_h;
  lflags_t [NSLOT-1:0]      slot_f;
  logic [NSLOT-1:0]         slot_we;
  logic [NSLOT-1:0]         slot_nv;
  logic [NSLOT-1:0][HW-1:0] slot_nh;
  lflags_t [NSLOT-1:0]      slot_nf;

  logic                     ev_hdr_wr;
  logic [HW-1:0]            ev_hdr_h;
  logic [NSLOT-1:0]         ev_rel;
  logic [NSLOT-1:0][HW-1:0] ev_rel_h;
  logic                     ev_done, ev_notify, ev_wb, ev_err;
  lflags_t                  cflags;

  assign cflags.notify = commit_notify_i;
  assign cflags.wb     = commit_wb_i;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      dlq_slot #(.HW(HW)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (slot_we[s]),
        .nxt_valid_i  (slot_nv[s]),
        .nxt_handle_i (slot_nh[s]),
        .nxt_flags_i  (slot_nf[s]),
        .valid_o      (slot_v[s]),
        .handle_o     (slot_h[s]),
        .flags_o      (slot_f[s])
      );
    end
  endgenerate

  dlq_ctrl #(.HW(HW)) u_ctrl (
    .drain_i         (drain_i),
    .single_i        (mode_single_i),
    .commit_i        (commit_i),
    .commit_handle_i (commit_handle_i),
    .commit_flags_i  (cflags),
    .frame_end_i     (frame_end_i),
    .hw_upd_i        (hw_upd_i),
    .bottom_i        (field_bottom_i),
    .cur_v_i         (slot_v),
    .cur_h_i         (slot_h),
    .cur_f_i         (slot_f),
    .we_o            (slot_we),
    .nxt_v_o         (slot_nv),
    .nxt_h_o         (slot_nh),
    .nxt_f_o         (slot_nf),
    .hdr_wr_o        (ev_hdr_wr),
    .hdr_handle_o    (ev_hdr_h),
    .rel_o           (ev_rel),
    .rel_h_o         (ev_rel_h),
    .done_o          (ev_done),
    .notify_o        (ev_notify),
    .wb_o            (ev_wb),
    .err_o           (ev_err)
  );

  dlq_outreg #(.HW(HW)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdr_wr_i     (ev_hdr_wr),
    .hdr_handle_i (ev_hdr_h),
    .rel_i        (ev_rel),
    .rel_h_i      (ev_rel_h),
    .done_i       (ev_done),
    .notify_i     (ev_notify),
    .wb_i         (ev_wb),
    .err_i        (ev_err),
    .hdr_wr_o     (hdr_wr_o),
    .hdr_handle_o (hdr_handle_o),
    .rel_o        (rel_o),
    .rel_h_o      (rel_handle_o),
    .done_o       (done_o),
    .notify_o     (notify_o),
    .wb_o         (wb_o),
    .err_o        (err_o)
  );
endmodule

// File: rtl/dlq_chk.sv
module dlq_chk import dlq_pkg::*; #(
  parameter int unsigned HW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                drain_i,
  input logic                mode_single_i,
  input logic                commit_i,
  input logic [HW-1:0]       commit_handle_i,
  input logic                frame_end_i,
  input logic                hw_upd_i,
  input logic                field_bottom_i,
  input logic                que_v,
  input logic                hdr_wr_o,
  input logic [HW-1:0]       hdr_handle_o,
  input logic [NSLOT-1:0]    rel_o,
  input logic                done_o,
  input logic                notify_o,
  input logic                wb_o,
  input logic                err_o
);
  // R12
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_i |=> (!hdr_wr_o && !done_o && !notify_o && !wb_o && !err_o));

  // R10
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_single_i && frame_end_i && !drain_i) |=> done_o);

  // R5
  bottom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_single_i && frame_end_i && field_bottom_i && !commit_i && !drain_i)
      |=> (!done_o && !hdr_wr_o && rel_o == '0 && !wb_o));

  // R11
  err_with_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> rel_o[SLOT_PEN]);

  // R6
  notify_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> done_o);

  // R3
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_single_i && commit_i && !drain_i && !(que_v && hw_upd_i))
      |=> (hdr_wr_o && hdr_handle_o == $past(commit_handle_i)));

  // R2
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_single_i && commit_i && !drain_i && que_v && hw_upd_i) |=> !hdr_wr_o);

  // R13
  race_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_single_i && commit_i && frame_end_i && !drain_i) |=> !done_o);
endmodule

bind dlq_commit_queue dlq_chk #(.HW(HW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .drain_i         (drain_i),
  .mode_single_i   (mode_single_i),
  .commit_i        (commit_i),
  .commit_handle_i (commit_handle_i),
  .frame_end_i     (frame_end_i),
  .hw_upd_i        (hw_upd_i),
  .field_bottom_i  (field_bottom_i),
  .que_v           (slot_v[1]),
  .hdr_wr_o        (hdr_wr_o),
  .hdr_handle_o    (hdr_handle_o),
  .rel_o           (rel_o),
  .done_o          (done_o),
  .notify_o        (notify_o),
  .wb_o            (wb_o),
  .err_o           (err_o)
);

// File: tb/sim_dlq_commit_queue.sv
`timescale 1ns/1ps
module sim_dlq_commit_queue;
  localparam int HW = 8;
  localparam int VW = 1 + HW + 3 + 3*HW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drain_i = 1'b0, mode_single_i = 1'b0, commit_i = 1'b0;
  logic [HW-1:0] commit_handle_i = '0;
  logic commit_notify_i = 1'b0, commit_wb_i = 1'b0, frame_end_i = 1'b0;
  logic hw_upd_i = 1'b0, field_bottom_i = 1'b0;
  logic hdr_wr_o;
  logic [HW-1:0] hdr_handle_o;
  logic [2:0] rel_o;
  logic [3*HW-1:0] rel_handle_o;
  logic done_o, notify_o, wb_o, err_o;

  always #5 clk = ~clk;

  dlq_commit_queue #(.HW(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .drain_i(drain_i), .mode_single_i(mode_single_i),
    .commit_i(commit_i), .commit_handle_i(commit_handle_i),
    .commit_notify_i(commit_notify_i), .commit_wb_i(commit_wb_i),
    .frame_end_i(frame_end_i), .hw_upd_i(hw_upd_i), .field_bottom_i(field_bottom_i),
    .hdr_wr_o(hdr_wr_o), .hdr_handle_o(hdr_handle_o), .rel_o(rel_o),
    .rel_handle_o(rel_handle_o), .done_o(done_o), .notify_o(notify_o),
    .wb_o(wb_o), .err_o(err_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit mode_r = 0;

  // behavioural model: -1 marks an empty slot
  int act = -1, que = -1, pen = -1;
  bit act_n, act_w, que_n, que_w, pen_n, pen_w;
  logic [VW-1:0] expv;

  function automatic logic [VW-1:0] actual();
    return {hdr_wr_o, hdr_handle_o, rel_o, rel_handle_o, done_o, notify_o, wb_o, err_o};
  endfunction

  task automatic model(input bit c, input int h, input bit cn, input bit cw,
                       input bit fe, input bit up, input bit bot, input bit dr);
    bit ew = 0, ed = 0, en = 0, eb = 0, ee = 0;
    int eh = 0;
    bit [2:0] er = 0;
    int rh [3] = '{0, 0, 0};
    bit busy;
    if (dr) begin
      if (act >= 0) begin er[0] = 1; rh[0] = act; end
      if (que >= 0) begin er[1] = 1; rh[1] = que; end
      if (pen >= 0) begin er[2] = 1; rh[2] = pen; end
      act = -1; que = -1; pen = -1;
    end else if (mode_r) begin
      if (fe) begin
        ed = 1;
        if (act >= 0) begin er[0] = 1; rh[0] = act; end
        act = -1;
      end
      if (c) begin
        ew = 1; eh = h;
        if (act >= 0) begin er[0] = 1; rh[0] = act; end
        act = h; act_n = cn; act_w = cw;
      end
    end else begin
      busy = (que >= 0) && up;
      if (c) begin
        if (busy) begin
          if (pen >= 0) begin er[2] = 1; rh[2] = pen; ee = pen_n; end
          pen = h; pen_n = cn; pen_w = cw;
        end else begin
          ew = 1; eh = h;
          if (que >= 0) begin er[1] = 1; rh[1] = que; end
          que = h; que_n = cn; que_w = cw;
        end
      end else if (fe && !busy && !bot) begin
        if (act >= 0 && act_w) begin eb = 1; act_w = 0; end
        if (que >= 0) begin
          ed = 1; en = que_n;
          if (act >= 0) begin er[0] = 1; rh[0] = act; end
          act = que; act_n = que_n; act_w = que_w; que = -1;
          if (pen >= 0) begin
            ew = 1; eh = pen;
            que = pen; que_n = pen_n; que_w = pen_w; pen = -1;
          end
        end
      end
    end
    expv = {ew, eh[HW-1:0], er, rh[2][HW-1:0], rh[1][HW-1:0], rh[0][HW-1:0], ed, en, eb, ee};
  endtask

  task automatic step(input string tag, input bit c, input int h, input bit cn, input bit cw,
                      input bit fe, input bit up, input bit bot, input bit dr);
    logic [VW-1:0] a;
    @(negedge clk);
    mode_single_i = mode_r; commit_i = c; commit_handle_i = h[HW-1:0];
    commit_notify_i = cn; commit_wb_i = cw; frame_end_i = fe;
    hw_upd_i = up; field_bottom_i = bot; drain_i = dr;
    model(c, h, cn, cw, fe, up, bot, dr);
    @(posedge clk);
    #2;
    a = actual();
    checks++;
    if (a !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, a, expv);
    end
  endtask

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (actual() !== '0) begin
      failures++;
      $display("FAIL R1 reset actual=%h expected=%h", actual(), {VW{1'b0}});
    end
    //           tag    c  h  n  w  fe up bt dr
    step("R1",  0, 0, 0, 0, 1, 0, 0, 0);
    step("R4",  1, 1, 0, 0, 0, 1, 0, 0);  // queued empty: busy bit ignored
    step("R2",  1, 2, 0, 0, 0, 1, 0, 0);
    step("R2",  1, 3, 1, 0, 0, 1, 0, 0);
    step("R11", 1, 4, 0, 0, 0, 1, 0, 0);
    step("R5",  0, 0, 0, 0, 1, 1, 0, 0);
    step("R5",  0, 0, 0, 0, 1, 0, 1, 0);
    step("R7",  0, 0, 0, 0, 1, 0, 0, 0);
    step("R6",  0, 0, 0, 0, 1, 0, 0, 0);
    step("R3",  1, 5, 1, 1, 0, 0, 0, 0);
    step("R3",  1, 6, 1, 1, 0, 0, 0, 0);
    step("R6",  0, 0, 0, 0, 1, 0, 0, 0);
    step("R8",  0, 0, 0, 0, 1, 0, 0, 0);
    step("R8",  0, 0, 0, 0, 1, 0, 0, 0);
    step("R13", 1, 9, 0, 0, 1, 0, 0, 0);
    step("R13", 1, 10, 0, 0, 1, 1, 0, 0);
    step("R12", 1, 11, 0, 0, 1, 1, 0, 1);
    step("R12", 0, 0, 0, 0, 1, 0, 0, 0);
    mode_r = 1;
    step("R9",  1, 20, 0, 0, 0, 0, 0, 0);
    step("R9",  1, 21, 0, 1, 0, 1, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R9",  1, 22, 0, 0, 0, 0, 0, 0);
    step("R13", 1, 23, 0, 0, 1, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 1);
    mode_r = 0;
    seed = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      int r;
      seed = seed * 1103515245 + 12345;
      r = (seed >>> 8) & 32'hFFFFF;
      step("R6", r[0] & r[1], ((r >> 4) % 255) + 1, r[12], r[13],
           r[2] | r[3], r[5] & r[6], r[7] & r[8] & r[9], (r[14:10] == 5'd3));
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule